// File: doc/BRIEF.md
# Residual Reconstruction Row Engine

This block rebuilds picture samples after an inverse transform. Each beat takes one row of a square block: a row of signed 16-bit residuals on one stream and a row of unsigned 8-bit predicted pixels on another. It returns one row of 8-bit reconstructed pixels. Each output pixel is the prediction plus its residual. The sum is first saturated to the signed 16-bit range and then clipped to 0..255. The block edge can be 4, 8, 16 or 32 samples, and a block of edge N takes exactly N beats.

For blocks whose only non-zero coefficient is the top-left one, a DC-only mode skips the transform. The block derives a single residual from that coefficient with fixed rounding and applies it to every position of the block, so the residual stream is not used at all. Block size, mode and DC coefficient come on header inputs that are sampled together with the first prediction row of each block. They are held internally until the block's last row has been taken.

Rows leave in arrival order through one registered output stage with a valid/ready handshake. A last-row marker flags the final row of each block.

Top module: `rr_recon`

## Requirements
- R1: `hdr_size_sel` values 0, 1, 2 and 3 select block edges of 4, 8, 16 and 32. A block of edge N consumes N input rows and emits N output rows. Lane k of a row sits at bits [8k+7:8k] of `out_row` (residual lane k at [16k+15:16k] of `res_row`). Lanes at or above N are driven to zero.
- R2: The header inputs (`hdr_size_sel`, `hdr_dc_mode`, `hdr_dc_coef`) are sampled only on the beat that accepts the first row of a block. Their values on later rows of that block have no effect on any output.
- R3: In DC-only mode (`hdr_dc_mode` = 1) the residual is computed from the signed coefficient c as t = (c + 1) >>> 1, then v = (t + 32) >>> 6, both shifts arithmetic.
- R4: In DC-only mode the single value v is the residual of every lane of every row of the block. `res_ready` stays low, so no residual row is consumed.
- R5: In normal mode each output lane equals the prediction pixel, zero-extended, plus the residual of the same lane, added with saturation to the signed 16-bit range.
- R6: The saturated sum is clipped to 8 bits: any negative value gives 0 and any value above 255 gives 255.
- R7: `out_last` is 1 on the final output row of each block and 0 on every other row.
- R8: Rows are emitted in input order. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_row` and `out_last` hold their values and no row is lost.
- R9: While `rst_n` is low, and after it is released, `out_valid` is 0 and no block is in progress. A reset in the middle of a block discards the partial block, and the next accepted row starts a new block.
- R10: In normal mode a prediction row and a residual row are consumed on the same beat: `pred_ready` and `res_ready` are both high when the row is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hdr_size_sel | input | 2 | Block edge select: 0=4, 1=8, 2=16, 3=32 |
| hdr_dc_mode | input | 1 | 1 selects DC-only mode for the block |
| hdr_dc_coef | input | 16 | Signed top-left coefficient for DC-only mode |
| res_valid | input | 1 | Residual row valid |
| res_ready | output | 1 | Residual row accepted on this beat |
| res_row | input | 512 | 32 signed 16-bit residual lanes |
| pred_valid | input | 1 | Prediction row valid |
| pred_ready | output | 1 | Prediction row accepted on this beat |
| pred_row | input | 256 | 32 unsigned 8-bit prediction lanes |
| out_valid | output | 1 | Reconstructed row valid |
| out_ready | input | 1 | Downstream accepts the row |
| out_row | output | 256 | 32 reconstructed 8-bit lanes |
| out_last | output | 1 | Final row of the block |

## Verification
The assertions assume that upstream keeps a row and the header stable while `pred_valid` is high and `pred_ready` is low. They also assume that in normal mode the two input streams belong to the same block. The bench drives every input on the falling edge. It holds a row until it sees the matching ready, and it changes the header fields only after the first row of a block has been accepted. DC blocks keep `res_valid` high with unrelated data, to show that the residual stream stays untouched. Some blocks toggle `out_ready` in a fixed pattern to exercise the stall path.

// File: rtl/rr_pkg.sv
package rr_pkg;

  localparam int RES_W = 16;
  localparam int PIX_W = 8;

  typedef logic signed [RES_W-1:0] res_t;
  typedef logic        [PIX_W-1:0] pix_t;

  // Signed add of a residual and a zero-extended pixel, saturated to RES_W bits.
  function automatic res_t sat_add(input res_t r, input pix_t p);
    logic signed [RES_W:0] s;
    logic signed [RES_W:0] pz;
    pz = $signed({{(RES_W+1-PIX_W){1'b0}}, p});
    s  = $signed({r[RES_W-1], r}) + pz;
    if (s[RES_W] != s[RES_W-1]) begin
      // overflow: sign of the wide sum picks the rail
      return s[RES_W] ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
    end
    return s[RES_W-1:0];
  endfunction

  // Unsigned clip of a signed value to PIX_W bits.
  function automatic pix_t clip_pix(input res_t v);
    if (v[RES_W-1])            return '0;
    else if (|v[RES_W-2:PIX_W]) return '1;
    else                        return v[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/rr_dc_calc.sv
module rr_dc_calc
  import rr_pkg::*;
(
  input  res_t coef,
  output res_t dc_val
);

  localparam int STAGE1_SH = 1;
  localparam int STAGE2_SH = 6;
  localparam logic signed [RES_W:0] RND1 = (RES_W+1)'(1);
  localparam logic signed [RES_W:0] RND2 = (RES_W+1)'(1 << (STAGE2_SH - 1));

  logic signed [RES_W:0] coef_ext;
  logic signed [RES_W:0] half_v;
  logic signed [RES_W:0] final_v;

  always_comb begin
    coef_ext = $signed({coef[RES_W-1], coef});
    half_v   = (coef_ext + RND1) >>> STAGE1_SH;
    final_v  = (half_v + RND2) >>> STAGE2_SH;
    dc_val   = final_v[RES_W-1:0];
  end

endmodule

// File: rtl/rr_lane.sv
module rr_lane
  import rr_pkg::*;
(
  input  logic lane_on,
  input  res_t res,
  input  pix_t pred,
  output pix_t pix
);

  res_t sum_sat;

  always_comb begin
    sum_sat = sat_add(res, pred);
    pix     = lane_on ? clip_pix(sum_sat) : '0;
  end

endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 5,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_sync_n,
  input  logic [SEL_W-1:0]    hdr_size_sel,
  input  logic                hdr_dc_mode,
  input  res_t                hdr_dc_coef,
  input  logic                res_valid,
  input  logic                pred_valid,
  input  logic                can_load,
  output logic                res_ready,
  output logic                pred_ready,
  output logic                fire,
  output logic                row_last,
  output logic                cur_dc,
  output res_t                cur_coef,
  output logic [MAX_LOG2:0]   cur_n
);

  localparam int ROW_W = MAX_LOG2;
  localparam int N_W   = MAX_LOG2 + 1;
  localparam int MIN_N = 1 << MIN_LOG2;

  logic               active_q, active_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic               dc_q, dc_d;
  res_t               coef_q, coef_d;
  logic [SEL_W-1:0]   cur_sel;
  logic               hdr_en;
  logic               row_en;

  // next state
  always_comb begin
    cur_sel    = active_q ? sel_q  : hdr_size_sel;
    cur_dc     = active_q ? dc_q   : hdr_dc_mode;
    cur_coef   = active_q ? coef_q : hdr_dc_coef;
    cur_n      = N_W'(MIN_N) << cur_sel;
    row_last   = ({1'b0, row_q} == (cur_n - N_W'(1)));

    pred_ready = can_load && (cur_dc || res_valid);
    res_ready  = can_load && pred_valid && !cur_dc;
    fire       = pred_valid && pred_ready;

    row_en     = fire;
    hdr_en     = fire && !active_q;
    sel_d      = hdr_size_sel;
    dc_d       = hdr_dc_mode;
    coef_d     = hdr_dc_coef;

    if (row_last) begin
      active_d = 1'b0;
      row_d    = '0;
    end else begin
      active_d = 1'b1;
      row_d    = row_q + ROW_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
    end else if (row_en) begin
      active_q <= active_d;
      row_q    <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q  <= '0;
      dc_q   <= 1'b0;
      coef_q <= '0;
    end else if (hdr_en) begin
      sel_q  <= sel_d;
      dc_q   <= dc_d;
      coef_q <= coef_d;
    end
  end

  // R2: header state frozen for the life of a block
  a_r2_hdr_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active_q && !(fire && row_last)) |=>
      (active_q && sel_q == $past(sel_q) && dc_q == $past(dc_q) && coef_q == $past(coef_q)));

  // R1: row counter stays inside the latched block edge
  a_r1_row_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active_q |-> ({1'b0, row_q} < (N_W'(MIN_N) << sel_q)));

  // R4: no residual consumed in DC-only mode
  a_r4_no_res_in_dc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pred_valid && cur_dc) |-> !res_ready);

  // R10: normal-mode rows taken on both streams together
  a_r10_joint_take: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !cur_dc) |-> (res_valid && res_ready));

endmodule

// File: rtl/rr_recon.sv
module rr_recon
  import rr_pkg::*;
#(
  parameter  int MIN_LOG2 = 2,
  parameter  int MAX_LOG2 = 5,
  localparam int MAX_N    = 1 << MAX_LOG2,
  localparam int SEL_W    = $clog2(MAX_LOG2 - MIN_LOG2 + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        hdr_size_sel,
  input  logic                    hdr_dc_mode,
  input  logic [RES_W-1:0]        hdr_dc_coef,
  input  logic                    res_valid,
  output logic                    res_ready,
  input  logic [MAX_N*RES_W-1:0]  res_row,
  input  logic                    pred_valid,
  output logic                    pred_ready,
  input  logic [MAX_N*PIX_W-1:0]  pred_row,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [MAX_N*PIX_W-1:0]  out_row,
  output logic                    out_last
);

  localparam int N_W   = MAX_LOG2 + 1;
  localparam int MIN_N = 1 << MIN_LOG2;
  localparam int ROW_BITS = MAX_N * PIX_W;

  // reset: asserted at once, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic             can_load;
  logic             fire;
  logic             row_last;
  logic             cur_dc;
  res_t             cur_coef;
  res_t             dc_val;
  logic [N_W-1:0]   cur_n;
  logic [ROW_BITS-1:0] row_nx;

  rr_ctrl #(
    .MIN_LOG2 (MIN_LOG2),
    .MAX_LOG2 (MAX_LOG2),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .hdr_size_sel (hdr_size_sel),
    .hdr_dc_mode  (hdr_dc_mode),
    .hdr_dc_coef  (res_t'(hdr_dc_coef)),
    .res_valid    (res_valid),
    .pred_valid   (pred_valid),
    .can_load     (can_load),
    .res_ready    (res_ready),
    .pred_ready   (pred_ready),
    .fire         (fire),
    .row_last     (row_last),
    .cur_dc       (cur_dc),
    .cur_coef     (cur_coef),
    .cur_n        (cur_n)
  );

  rr_dc_calc u_dc (
    .coef   (cur_coef),
    .dc_val (dc_val)
  );

  for (genvar i = 0; i < MAX_N; i++) begin : g_lane
    logic lane_on;
    res_t lane_res;
    assign lane_on  = (N_W'(i) < cur_n);
    assign lane_res = cur_dc ? dc_val : res_t'(res_row[i*RES_W +: RES_W]);
    rr_lane u_lane (
      .lane_on (lane_on),
      .res     (lane_res),
      .pred    (pred_row[i*PIX_W +: PIX_W]),
      .pix     (row_nx[i*PIX_W +: PIX_W])
    );
  end

  // output stage
  logic                out_valid_q, out_valid_d;
  logic [ROW_BITS-1:0] out_row_q;
  logic                out_last_q;
  logic [N_W-1:0]      out_n_q;
  logic                out_en;

  always_comb begin
    can_load    = !out_valid_q || out_ready;
    out_valid_d = fire || (out_valid_q && !out_ready);
    out_en      = fire;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_row_q  <= '0;
      out_last_q <= 1'b0;
      out_n_q    <= N_W'(MIN_N);
    end else if (out_en) begin
      out_row_q  <= row_nx;
      out_last_q <= row_last;
      out_n_q    <= cur_n;
    end
  end

  assign out_valid = out_valid_q;
  assign out_row   = out_row_q;
  assign out_last  = out_last_q;

  // R8: a stalled row is held unchanged
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid_q && !out_ready) |=>
      (out_valid_q && $stable(out_row_q) && $stable(out_last_q)));

  // R1: lanes beyond the block edge are zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid_q |-> ((out_row_q >> (PIX_W * int'(out_n_q))) == '0));

  // R7: two block ends are never adjacent rows
  a_r7_last_spaced: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid_q && out_ready && out_last_q) |=> !(out_valid_q && out_last_q));

endmodule

// File: tb/tb_rr_recon.sv
`timescale 1ns/1ps
module tb_rr_recon;

  localparam int MAXN = 32;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic [1:0]           hdr_size_sel;
  logic                 hdr_dc_mode;
  logic [15:0]          hdr_dc_coef;
  logic                 res_valid, res_ready;
  logic [MAXN*16-1:0]   res_row;
  logic                 pred_valid, pred_ready;
  logic [MAXN*8-1:0]    pred_row;
  logic                 out_valid, out_ready;
  logic [MAXN*8-1:0]    out_row;
  logic                 out_last;

  rr_recon dut (
    .clk(clk), .rst_n(rst_n),
    .hdr_size_sel(hdr_size_sel), .hdr_dc_mode(hdr_dc_mode), .hdr_dc_coef(hdr_dc_coef),
    .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_row(pred_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_last(out_last)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;
  bit res_seen_dc;
  bit joint_bad;

  // {dc, value(coef or residual), pred, expected}
  localparam int NTV = 22;
  localparam logic [32:0] TV [NTV] = '{
    {1'b0, 16'h000A, 8'd100, 8'd110},
    {1'b0, 16'hFF38, 8'd50,  8'd0  },
    {1'b0, 16'h012C, 8'd10,  8'd255},
    {1'b0, 16'h7FFF, 8'd255, 8'd255},
    {1'b0, 16'h8000, 8'd0,   8'd0  },
    {1'b0, 16'h0000, 8'd255, 8'd255},
    {1'b0, 16'hFFFF, 8'd0,   8'd0  },
    {1'b0, 16'hFFFF, 8'd1,   8'd0  },
    {1'b0, 16'hFFFB, 8'd5,   8'd0  },
    {1'b0, 16'h0005, 8'd250, 8'd255},
    {1'b1, 16'h0000, 8'd77,  8'd77 },
    {1'b1, 16'h0040, 8'd77,  8'd78 },
    {1'b1, 16'h003E, 8'd77,  8'd77 },
    {1'b1, 16'h003F, 8'd77,  8'd78 },
    {1'b1, 16'h00BF, 8'd77,  8'd79 },
    {1'b1, 16'h00BE, 8'd77,  8'd78 },
    {1'b1, 16'hFFFE, 8'd77,  8'd77 },
    {1'b1, 16'hFF80, 8'd77,  8'd76 },
    {1'b1, 16'hFF3E, 8'd77,  8'd75 },
    {1'b1, 16'hFF3F, 8'd77,  8'd76 },
    {1'b1, 16'h7FFF, 8'd10,  8'd255},
    {1'b1, 16'h8000, 8'd255, 8'd0  }
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int gen_res(int s, int r, int l);
    return ((r * 37 + l * 91 + s * 13) % 700) - 350;
  endfunction

  function automatic int gen_pred(int s, int r, int l);
    return (r * 11 + l * 29 + s * 7) % 256;
  endfunction

  function automatic int ref_pix(int res, int pred);
    int s;
    s = res + pred;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    if (s < 0)   return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  task automatic drive_block(input int sel, input bit dc, input logic [15:0] coef,
                             input bit uni, input logic [15:0] ures, input logic [7:0] upred,
                             input int seed, input bit junk);
    int n;
    n = 4 << sel;
    for (int r = 0; r < n; r++) begin
      @(negedge clk);
      if (r == 0 || !junk) begin
        hdr_size_sel = 2'(sel);
        hdr_dc_mode  = dc;
        hdr_dc_coef  = coef;
      end else begin
        hdr_size_sel = 2'((sel + 1) % 4);
        hdr_dc_mode  = !dc;
        hdr_dc_coef  = ~coef;
      end
      for (int l = 0; l < MAXN; l++) begin
        res_row[l*16 +: 16] = uni ? ures  : 16'(gen_res(seed, r, l));
        pred_row[l*8 +: 8]  = uni ? upred : 8'(gen_pred(seed, r, l));
      end
      pred_valid = 1'b1;
      res_valid  = 1'b1;
      #1;
      while (!pred_ready) begin
        if (dc && res_ready) res_seen_dc = 1'b1;
        @(negedge clk);
        #1;
      end
      if (dc && res_ready)  res_seen_dc = 1'b1;
      if (!dc && !res_ready) joint_bad = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    pred_valid = 1'b0;
    res_valid  = 1'b0;
  endtask

  task automatic recv_block(input int sel, input bit dc, input bit uni, input logic [7:0] uexp,
                            input int dcval, input int seed, input bit stall, input string req);
    int n, got, cyc;
    bit pend;
    logic [255:0] held, exp_row;
    n = 4 << sel;
    got = 0; cyc = 0; pend = 1'b0; held = '0;
    while (got < n) begin
      @(negedge clk);
      out_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      cyc++;
      #1;
      if (pend) begin
        chk(out_valid && out_row == held, "R8", "stalled row held", out_row, held);
        pend = 1'b0;
      end
      if (out_valid && !out_ready) begin
        held = out_row;
        pend = 1'b1;
      end
      if (out_valid && out_ready) begin
        exp_row = '0;
        for (int l = 0; l < n; l++) begin
          if (uni) exp_row[l*8 +: 8] = uexp;
          else exp_row[l*8 +: 8] = 8'(ref_pix(dc ? dcval : gen_res(seed, got, l),
                                               gen_pred(seed, got, l)));
        end
        chk(out_row == exp_row, req, $sformatf("row %0d data (R1 upper lanes zero)", got),
            out_row, exp_row);
        chk(out_last == (got == n - 1), "R7", $sformatf("last flag row %0d", got),
            256'(out_last), 256'(got == n - 1));
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_block(input int sel, input bit dc, input logic [15:0] coef,
                           input bit uni, input logic [15:0] ures, input logic [7:0] upred,
                           input logic [7:0] uexp, input int dcval, input int seed,
                           input bit junk, input bit stall, input string req);
    res_seen_dc = 1'b0;
    joint_bad   = 1'b0;
    fork
      drive_block(sel, dc, coef, uni, ures, upred, seed, junk);
      recv_block(sel, dc, uni, uexp, dcval, seed, stall, req);
    join
    if (dc) chk(!res_seen_dc, "R4", "res_ready low during DC block", 256'(res_seen_dc), 256'(0));
    else    chk(!joint_bad, "R10", "res_ready with pred_ready", 256'(joint_bad), 256'(0));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", wd, WD_LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hdr_size_sel = '0; hdr_dc_mode = 1'b0; hdr_dc_coef = '0;
    res_valid = 1'b0; pred_valid = 1'b0; res_row = '0; pred_row = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", 256'(out_valid), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && pred_ready == 1'b0, "R9", "idle after reset",
        256'({out_valid, pred_ready}), 256'(0));

    // table of uniform 4x4 blocks: R5/R6 normal, R3/R4 DC
    for (int i = 0; i < NTV; i++) begin
      run_block(0, TV[i][32], TV[i][31:16], 1'b1, TV[i][31:16], TV[i][15:8], TV[i][7:0],
                0, 0, 1'b0, 1'b0, TV[i][32] ? "R3" : "R6");
    end

    // varied data at each size
    run_block(1, 1'b0, 16'h0, 1'b0, 16'h0, 8'h0, 8'h0, 0, 1, 1'b0, 1'b0, "R5");
    run_block(2, 1'b0, 16'h0, 1'b0, 16'h0, 8'h0, 8'h0, 0, 2, 1'b0, 1'b1, "R5");
    run_block(3, 1'b0, 16'h0, 1'b0, 16'h0, 8'h0, 8'h0, 0, 3, 1'b1, 1'b0, "R2");
    // DC, coef 191 -> residual 2, header noise on later rows, stalls
    run_block(3, 1'b1, 16'h00BF, 1'b0, 16'h0, 8'h0, 8'h0, 2, 4, 1'b1, 1'b1, "R4");
    // DC, coef -194 -> residual -2
    run_block(2, 1'b1, 16'hFF3E, 1'b0, 16'h0, 8'h0, 8'h0, -2, 5, 1'b1, 1'b0, "R4");

    // reset in the middle of a 32-row block
    @(negedge clk);
    hdr_size_sel = 2'd3; hdr_dc_mode = 1'b0;
    pred_valid = 1'b1; res_valid = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    pred_valid = 1'b0; res_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid cleared by mid-block reset", 256'(out_valid), 256'(0));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_block(0, 1'b0, 16'h0, 1'b1, 16'h0003, 8'd40, 8'd43, 0, 0, 1'b0, 1'b0, "R9");

    summary();
    $finish;
  end

endmodule